// File: doc/BRIEF.md
# Programmable Interrupt Priority Router

This block arbitrates interrupts from three on-chip peripherals: a counter/timer, a serial controller and a parallel port. It also passes arbitration on to an external daisy chain of further devices. Each internal source presents a request line and an in-service flag. The router walks the sources in a priority order held in a small write-only register and issues at most one grant. Whichever source is first in that order and either requesting or being serviced stops every source behind it. That source is granted only if it is requesting and not already in service.

Software picks one of six orders by writing a code to the priority register. The register is mapped at low I/O address byte 0xF4 and mirrored across the upper address byte. Codes 6 and 7 have no order of their own: they fold onto 2 and 3 and set a sticky flag. The external chain always ranks below all three internal sources. It receives an enable only when no internal source is requesting or in service. The block also decodes the chip selects for the three peripheral register windows and drives one interrupt line to the processor.

Top module: `irq_prio_router`

## Requirements
- R1: A write with `io_wr` high and `io_addr[7:0]` = 0xF4 loads `io_data[2:0]` into the priority code at the next rising clock edge, whatever the upper address byte. `io_data[7:3]` is discarded.
- R2: The code sets the order, highest first (grant bit 0 = timer, 1 = serial, 2 = parallel): 0 timer,serial,parallel; 1 serial,timer,parallel; 2 timer,parallel,serial; 3 parallel,serial,timer; 4 parallel,timer,serial; 5 serial,parallel,timer.
- R3: A written value of 6 behaves as 2 and a value of 7 behaves as 3. Either one sets `bad_code`, which stays high until reset.
- R4: Reset sets the code to 0 and clears `bad_code`.
- R5: An internal source is granted only if it requests and is not in service, and no source ahead of it in the current order is requesting or in service.
- R6: `ext_chain_en` is high only when no internal source is requesting or in service. `grant[3]` equals `ext_chain_en & ext_req`.
- R7: `grant` is one-hot or all zero in every cycle, including the cycle in which the code changes.
- R8: `cpu_int` is high exactly when some bit of `grant` is high.
- R9: Chip selects depend only on `io_addr[7:0]`: `cs_timer` for 0x10–0x13, `cs_serial` for 0x18–0x1B, `cs_parallel` for 0x1C–0x1F.
- R10: A write to any other low address byte, or a bus cycle with `io_wr` low, leaves the code unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous |
| io_addr | input | 16 | I/O address |
| io_data | input | 8 | I/O write data |
| io_wr | input | 1 | I/O write strobe |
| src_req | input | 3 | Internal requests (bit 0 timer, 1 serial, 2 parallel) |
| src_ius | input | 3 | Internal in-service flags, same bit order |
| ext_req | input | 1 | Request from the external chain |
| cs_timer | output | 1 | Timer window select |
| cs_serial | output | 1 | Serial window select |
| cs_parallel | output | 1 | Parallel window select |
| grant | output | 4 | One-hot grant; bit 3 = external chain |
| ext_chain_en | output | 1 | Priority enable passed to the external chain |
| cpu_int | output | 1 | Interrupt to the processor |
| bad_code | output | 1 | Sticky flag: an undefined code was written |

## Verification
A wrong stored code is visible on the grant lines as soon as two or more sources request together. The bench therefore sweeps every code against all request, in-service and external combinations in the clock period after each write. A code that folds incorrectly shows as a wrong winner under codes 6 and 7. A lost or spurious load shows when grants are compared after writes to mirrored, neighbouring and strobe-less addresses. A corrupted sticky flag shows on `bad_code` at the next sample.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

   localparam int NSRC   = 3;
   localparam int SRC_W  = 2;
   localparam int CODE_W = 3;

   typedef enum logic [SRC_W-1:0] {
      SRC_TMR = 2'd0,
      SRC_SER = 2'd1,
      SRC_PAR = 2'd2
   } src_e;

   // Source index at chain position pos (0 = highest) for a given code.
   // Row layout: {pos2, pos1, pos0}.
   function automatic logic [SRC_W-1:0] order_at(input logic [CODE_W-1:0] code, input int pos);
      logic [NSRC*SRC_W-1:0] row;
      case (code)
         3'd0:    row = {SRC_PAR, SRC_SER, SRC_TMR};
         3'd1:    row = {SRC_PAR, SRC_TMR, SRC_SER};
         3'd2:    row = {SRC_SER, SRC_PAR, SRC_TMR};
         3'd3:    row = {SRC_TMR, SRC_SER, SRC_PAR};
         3'd4:    row = {SRC_SER, SRC_TMR, SRC_PAR};
         3'd5:    row = {SRC_TMR, SRC_PAR, SRC_SER};
         default: row = {SRC_PAR, SRC_SER, SRC_TMR};
      endcase
      return row[pos*SRC_W +: SRC_W];
   endfunction

endpackage

// File: rtl/irq_io_decode.sv
module irq_io_decode #(
   parameter int                      ADDR_W    = 16,
   parameter int                      DEC_W     = 8,
   parameter int                      WIN_LG2   = 2,
   parameter int                      NWIN      = 3,
   parameter logic [NWIN*DEC_W-1:0]   WIN_BASES = {8'h1C, 8'h18, 8'h10},
   parameter logic [DEC_W-1:0]        REG_ADDR  = 8'hF4
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [NWIN-1:0]   win_sel,
   output logic              reg_hit
);
   localparam int TAG_W = DEC_W - WIN_LG2;

   if (DEC_W > ADDR_W) begin : g_chk_dec
      $error("irq_io_decode: DEC_W exceeds ADDR_W");
   end
   if (WIN_LG2 >= DEC_W) begin : g_chk_win
      $error("irq_io_decode: window larger than decoded space");
   end

   logic [DEC_W-1:0] low;
   assign low = addr[DEC_W-1:0];

   for (genvar w = 0; w < NWIN; w++) begin : g_win
      localparam logic [DEC_W-1:0] BASE = WIN_BASES[w*DEC_W +: DEC_W];
      assign win_sel[w] = (low[DEC_W-1:WIN_LG2] == BASE[DEC_W-1:WIN_LG2]);
   end

   assign reg_hit = (low == REG_ADDR);

   logic unused_tag;
   assign unused_tag = ^TAG_W;
endmodule

// File: rtl/irq_prio_reg.sv
module irq_prio_reg #(
   parameter int DATA_W = 8,
   parameter int CODE_W = 3,
   parameter int NCODES = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic [CODE_W-1:0] code,
   output logic              undef_seen
);
   localparam logic [CODE_W-1:0] FOLD_MASK = CODE_W'((1 << (CODE_W-1)) - 1);
   localparam logic [CODE_W-1:0] LIMIT     = CODE_W'(NCODES);

   if (DATA_W < CODE_W) begin : g_chk_w
      $error("irq_prio_reg: data bus narrower than code");
   end
   if (NCODES > (1 << CODE_W)) begin : g_chk_n
      $error("irq_prio_reg: too many codes for CODE_W");
   end

   logic [CODE_W-1:0] raw;
   logic              undef;
   assign raw   = wr_data[CODE_W-1:0];
   assign undef = (raw >= LIMIT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code       <= '0;
         undef_seen <= 1'b0;
      end else if (wr_en) begin
         code <= undef ? (raw & FOLD_MASK) : raw;
         if (undef) undef_seen <= 1'b1;
      end
   end
endmodule

// File: rtl/irq_daisy_route.sv
module irq_daisy_route
   import irq_router_pkg::*;
#(
   parameter int N = 3
) (
   input  logic [CODE_W-1:0] code,
   input  logic [N-1:0]      req,
   input  logic [N-1:0]      ius,
   input  logic              ext_req,
   output logic [N:0]        grant,
   output logic              ext_en
);
   if (N != NSRC) begin : g_chk_n
      $error("irq_daisy_route: order table covers exactly NSRC sources");
   end

   logic [SRC_W-1:0] sel [N];
   logic [N:0]       en;
   logic [N-1:0]     win_pos;
   logic [N*N-1:0]   hit;

   assign en[0] = 1'b1;

   for (genvar p = 0; p < N; p++) begin : g_pos
      assign sel[p]     = order_at(code, p);
      assign win_pos[p] = en[p] & req[sel[p]] & ~ius[sel[p]];
      assign en[p+1]    = en[p] & ~req[sel[p]] & ~ius[sel[p]];
   end

   for (genvar s = 0; s < N; s++) begin : g_src
      for (genvar p = 0; p < N; p++) begin : g_map
         assign hit[s*N + p] = win_pos[p] & (sel[p] == SRC_W'(s));
      end
      assign grant[s] = |hit[s*N +: N];
   end

   assign ext_en   = en[N];
   assign grant[N] = en[N] & ext_req;
endmodule

// File: rtl/irq_prio_router.sv
module irq_prio_router
   import irq_router_pkg::*;
#(
   parameter int              ADDR_W   = 16,
   parameter int              DATA_W   = 8,
   parameter int              DEC_W    = 8,
   parameter logic [7:0]      PRIO_REG = 8'hF4,
   parameter logic [7:0]      TMR_BASE = 8'h10,
   parameter logic [7:0]      SER_BASE = 8'h18,
   parameter logic [7:0]      PAR_BASE = 8'h1C
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic [DATA_W-1:0] io_data,
   input  logic              io_wr,
   input  logic [NSRC-1:0]   src_req,
   input  logic [NSRC-1:0]   src_ius,
   input  logic              ext_req,
   output logic              cs_timer,
   output logic              cs_serial,
   output logic              cs_parallel,
   output logic [NSRC:0]     grant,
   output logic              ext_chain_en,
   output logic              cpu_int,
   output logic              bad_code
);
   localparam int NWIN = NSRC;

   if (DEC_W != 8) begin : g_chk_dec
      $error("irq_prio_router: window constants assume an 8-bit decoded field");
   end

   logic [NWIN-1:0]   win_sel;
   logic              reg_hit;
   logic [CODE_W-1:0] code_q;

   irq_io_decode #(
      .ADDR_W   (ADDR_W),
      .DEC_W    (DEC_W),
      .WIN_LG2  (2),
      .NWIN     (NWIN),
      .WIN_BASES({PAR_BASE, SER_BASE, TMR_BASE}),
      .REG_ADDR (PRIO_REG)
   ) u_dec (
      .addr    (io_addr),
      .win_sel (win_sel),
      .reg_hit (reg_hit)
   );

   irq_prio_reg #(
      .DATA_W (DATA_W),
      .CODE_W (CODE_W),
      .NCODES (6)
   ) u_reg (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (io_wr & reg_hit),
      .wr_data    (io_data),
      .code       (code_q),
      .undef_seen (bad_code)
   );

   irq_daisy_route #(
      .N (NSRC)
   ) u_route (
      .code    (code_q),
      .req     (src_req),
      .ius     (src_ius),
      .ext_req (ext_req),
      .grant   (grant),
      .ext_en  (ext_chain_en)
   );

   assign cs_timer    = win_sel[SRC_TMR];
   assign cs_serial   = win_sel[SRC_SER];
   assign cs_parallel = win_sel[SRC_PAR];
   assign cpu_int     = |grant;
endmodule

// File: rtl/irq_prio_router_chk.sv
module irq_prio_router_chk (
   input logic        clk,
   input logic        rst_n,
   input logic [15:0] io_addr,
   input logic [7:0]  io_data,
   input logic        io_wr,
   input logic [2:0]  src_req,
   input logic [2:0]  src_ius,
   input logic        ext_req,
   input logic        cs_timer,
   input logic        cs_serial,
   input logic        cs_parallel,
   input logic [3:0]  grant,
   input logic        ext_chain_en,
   input logic        cpu_int,
   input logic        bad_code,
   input logic [2:0]  code_q
);
   logic wr_hit;
   assign wr_hit = io_wr && (io_addr[7:0] == 8'hF4);

   assert_code_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit && io_data[2:0] < 3'd6) |=> (code_q == $past(io_data[2:0])));

   assert_fold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit && io_data[2:0] > 3'd5) |=> (code_q == {1'b0, $past(io_data[1:0])} && bad_code));

   assert_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
      bad_code |=> bad_code);

   assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_hit |=> $stable(code_q));

   assert_eligible_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (grant[2:0] & ~(src_req & ~src_ius)) == 3'b000);

   assert_ext_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
      grant[3] |-> (src_req == 3'b000 && src_ius == 3'b000 && ext_req && ext_chain_en));

   assert_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));

   assert_int_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_int == ($countones(grant) == 1));

   assert_cs_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
      cs_timer |-> (io_addr[7:0] >= 8'h10 && io_addr[7:0] <= 8'h13));

   assert_cs_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({cs_timer, cs_serial, cs_parallel}));
endmodule

bind irq_prio_router irq_prio_router_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .io_addr      (io_addr),
   .io_data      (io_data),
   .io_wr        (io_wr),
   .src_req      (src_req),
   .src_ius      (src_ius),
   .ext_req      (ext_req),
   .cs_timer     (cs_timer),
   .cs_serial    (cs_serial),
   .cs_parallel  (cs_parallel),
   .grant        (grant),
   .ext_chain_en (ext_chain_en),
   .cpu_int      (cpu_int),
   .bad_code     (bad_code),
   .code_q       (code_q)
);

// File: tb/sim_irq_prio_router.sv
module sim_irq_prio_router;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] io_addr = '0;
   logic [7:0]  io_data = '0;
   logic        io_wr = 1'b0;
   logic [2:0]  src_req = '0;
   logic [2:0]  src_ius = '0;
   logic        ext_req = 1'b0;
   logic        cs_timer, cs_serial, cs_parallel;
   logic [3:0]  grant;
   logic        ext_chain_en, cpu_int, bad_code;

   int total = 0;
   int bad = 0;
   int cycles = 0;
   bit done = 0;

   always #5 clk = ~clk;

   irq_prio_router u0 (
      .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_data(io_data), .io_wr(io_wr),
      .src_req(src_req), .src_ius(src_ius), .ext_req(ext_req),
      .cs_timer(cs_timer), .cs_serial(cs_serial), .cs_parallel(cs_parallel),
      .grant(grant), .ext_chain_en(ext_chain_en), .cpu_int(cpu_int), .bad_code(bad_code)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Source at rank r (0 highest) for order code c: 0 timer, 1 serial, 2 parallel.
   function automatic int rank_src(input int c, input int r);
      int t [6][3] = '{'{0,1,2}, '{1,0,2}, '{0,2,1}, '{2,1,0}, '{2,0,1}, '{1,2,0}};
      return t[c][r];
   endfunction

   function automatic int eff_code(input int c);
      return (c > 5) ? (c % 4) : c;
   endfunction

   // Returns {ext_en, grant[3:0]}
   function automatic int model(input int c, input int rq, input int is, input int ex);
      int g = 0;
      bit en = 1;
      for (int r = 0; r < 3; r++) begin
         int s = rank_src(c, r);
         bit q = rq[s];
         bit v = is[s];
         if (en && q && !v) g = 1 << s;
         if (q || v) en = 0;
      end
      if (en && ex != 0) g = 8;
      return (int'(en) << 4) | g;
   endfunction

   task automatic wr(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      io_addr = a; io_data = d; io_wr = 1'b1;
      @(negedge clk);
      io_wr = 1'b0; io_addr = 16'h0000; io_data = 8'h00;
   endtask

   task automatic probe(input int c, input int rq, input int is, input int ex, input string req);
      int e;
      src_req = 3'(rq); src_ius = 3'(is); ext_req = ex[0];
      #1;
      e = model(c, rq, is, ex);
      chk(grant == 4'(e), req, int'(grant), e & 15);
      chk(ext_chain_en == e[4], "R6", int'(ext_chain_en), e >> 4);
      chk(cpu_int == ((e & 15) != 0), "R8", int'(cpu_int), int'((e & 15) != 0));
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000 && !done) begin
         done = 1;
         bad++; total++;
         $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R4: reset state
      chk(bad_code == 1'b0, "R4", int'(bad_code), 0);
      probe(0, 7, 0, 1, "R4");

      // R9: chip-select sweep with varied upper byte
      for (int a = 0; a < 256; a++) begin
         logic [2:0] e;
         io_addr = {8'(a * 37 + 5), 8'(a)};
         #1;
         e = {a >= 28 && a <= 31, a >= 24 && a <= 27, a >= 16 && a <= 19};
         chk({cs_parallel, cs_serial, cs_timer} == e, "R9",
             int'({cs_parallel, cs_serial, cs_timer}), int'(e));
         @(negedge clk);
      end
      io_addr = '0;

      // R1/R2/R3/R5/R6/R7: every code against every input pattern
      for (int c = 0; c < 8; c++) begin
         wr({8'(c * 41 + 1), 8'hF4}, {5'(c * 7 + 3), 3'(c)});
         chk(bad_code == (c > 5), "R3", int'(bad_code), int'(c > 5));
         for (int v = 0; v < 128; v++) begin
            probe(eff_code(c), v & 7, (v >> 3) & 7, v >> 6, (c > 5) ? "R3" : "R2");
         end
      end

      // R10: misses and strobe-less cycles leave code 3 (folded from 7)
      wr(16'h00F5, 8'h00);
      wr(16'h01F0, 8'h01);
      @(negedge clk);
      io_addr = 16'h00F4; io_data = 8'h00;
      @(negedge clk);
      io_addr = 16'h0000;
      probe(3, 7, 0, 1, "R10");
      probe(3, 3, 0, 1, "R10");

      // R1: mirrored address, upper data bits discarded; R3 flag stays set
      wr(16'hABF4, 8'hF9);
      probe(1, 7, 0, 0, "R1");
      probe(1, 5, 0, 0, "R1");
      chk(bad_code == 1'b1, "R3", int'(bad_code), 1);

      // R5: in-service blocks lower, but not higher
      wr(16'h00F4, 8'h04);          // parallel, timer, serial
      probe(4, 3, 4, 0, "R5");      // parallel in service -> nothing
      probe(4, 2, 1, 1, "R5");      // timer in service blocks serial and ext
      probe(4, 1, 2, 0, "R5");      // timer ahead of serviced serial -> timer

      // R7: code change with all requests present
      src_req = 3'b111; src_ius = 3'b000; ext_req = 1'b1;
      @(negedge clk);
      io_addr = 16'h00F4; io_data = 8'h05; io_wr = 1'b1;
      @(posedge clk); #1;
      chk($countones(grant) == 1, "R7", int'(grant), 1);
      @(negedge clk);
      io_wr = 1'b0;
      probe(5, 7, 0, 1, "R7");

      // R4: second reset clears sticky flag and code
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(bad_code == 1'b0, "R4", int'(bad_code), 0);
      probe(0, 6, 0, 0, "R4");

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule